// File: doc/BRIEF.md
# IOTLB Invalidation Command Register

This block holds the 64-bit command word that software uses to invalidate an I/O translation cache. Software writes a requested granularity (global, domain or page), a domain identifier and two drain-request flags, then sets the busy bit. The block passes the request to an invalidation engine with a one-cycle strobe and keeps busy set until the engine answers with a one-cycle done strobe. It then clears busy and records the granularity that was actually carried out. That value is never finer than the request, and it is zero if the engine flags the request as malformed.

Capability inputs set how many domain-id bits exist and whether read or write draining is supported. Unsupported bits are dropped when written and read back as zero. Access goes through a synchronous port: writes use byte enables, and read data is registered.

Top module: `iotlb_inv_cmd`

## Requirements
- R1: After reset the register reads 0x0200_0000_0000_0000 and `eng_req` is low.
- R2: Bits 62, 59, 56:50, 47:40 and 31:0 always read zero, whatever was written to them.
- R3: The domain id sits at bits 39:32. Only its low N bits are kept, where N = min(`cap_did_width`, 8). The rest read zero and are never sent to the engine.
- R4: A write stores the read-drain flag at bit 49 only when `cap_drain_rd` is 1, and the write-drain flag at bit 48 only when `cap_drain_wr` is 1. Otherwise the flag is stored as 0.
- R5: A write with lane 7 enabled, bit 63 = 1 and a non-zero code in bits 61:60 (01 global, 10 domain, 11 page) sets busy. The cycle after the write, `eng_req` is high for exactly one cycle and carries the code, the masked domain id and the drain flags.
- R6: While busy reads 1, every write is ignored in full.
- R7: A `eng_done` while busy (and not in the `eng_req` cycle) clears busy. It also writes the engine's granularity into bits 58:57, provided that code is not finer than the request. Larger codes are finer.
- R8: If the engine returns a finer code than requested, or code 00 without error, the requested code is recorded in bits 58:57.
- R9: If `eng_done_err` is set with done, bits 58:57 become 00.
- R10: A start write whose requested code is 00 raises no `eng_req`, leaves busy at 0 and sets bits 58:57 to 00.
- R11: `eng_done` while not busy has no effect.
- R12: `rd_data` takes the register value from before the edge on a cycle with `rd_en`, and holds its value otherwise.
- R13: Only byte lanes 7 (busy, requested code), 6 (drain flags) and 4 (domain id) are writable. Each is changed only when its `wr_be` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_did_width | input | 4 | Supported domain-id width N |
| cap_drain_rd | input | 1 | Read draining supported |
| cap_drain_wr | input | 1 | Write draining supported |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 8 | Byte enables |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Registered read data |
| eng_req | output | 1 | One-cycle request to the engine |
| eng_gran | output | 2 | Requested granularity |
| eng_did | output | 8 | Masked domain id |
| eng_drain_rd | output | 1 | Effective read-drain flag |
| eng_drain_wr | output | 1 | Effective write-drain flag |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_done_gran | input | 2 | Granularity the engine performed |
| eng_done_err | input | 1 | Request was malformed and ignored |

## Verification
A wrong busy state shows up at once. It either blocks the next write or lets it through, and it shows in bit 63 on the next read. A bad sequencer state also appears as a missing, doubled or stretched `eng_req` on the cycle after the start write. A wrong clamp or error path only becomes visible in bits 58:57, on the first read after the done strobe. For that reason the bench compares `rd_data` and the engine outputs against a behavioural model on every clock. It also reads the register back after every completion.

// File: rtl/iotlb_inv_pkg.sv
// Shared types and field positions for the invalidation command register.
// Assumes a 64-bit word; positions of the granularity, busy and domain
// fields are fixed because software decodes them.
package iotlb_inv_pkg;

    typedef enum logic [1:0] {
        GR_NONE   = 2'b00,
        GR_GLOBAL = 2'b01,
        GR_DOMAIN = 2'b10,
        GR_PAGE   = 2'b11
    } gran_e;

    localparam int WORD_W   = 64;
    localparam int BUSY_BIT = 63;
    localparam int REQ_LO   = 60;
    localparam int ACT_LO   = 57;
    localparam int DRD_BIT  = 49;
    localparam int DWR_BIT  = 48;
    localparam int DID_LO   = 32;

    // Pick the granularity to report: never finer than requested, 00 on error.
    function automatic gran_e coarsen(gran_e req, logic [1:0] done, logic err);
        if (err)
            return GR_NONE;
        if (done == 2'b00 || done > req)
            return req;
        return gran_e'(done);
    endfunction

endpackage

// File: rtl/iotlb_inv_fields.sv
// Holds the software-written request fields: domain id and drain flags.
// Assumes the domain mask is already derived from the capability width and
// that the caller passes the current busy state (writes blocked while busy).
module iotlb_inv_fields
    import iotlb_inv_pkg::*;
#(
    parameter int DID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [7:0]       wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [DID_W-1:0] did_mask,
    input  logic             cap_rd,
    input  logic             cap_wr,
    output logic [DID_W-1:0] did_q,
    output logic             drd_q,
    output logic             dwr_q
);

    localparam int DID_LANE   = DID_LO / 8;
    localparam int DRAIN_LANE = DWR_BIT / 8;

    logic wr_ok;
    assign wr_ok = wr_en && !busy;

    // Store domain id and drain flags, dropping bits the capabilities exclude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            did_q <= '0;
            drd_q <= 1'b0;
            dwr_q <= 1'b0;
        end else if (wr_ok) begin
            if (wr_be[DID_LANE])
                did_q <= wr_data[DID_LO +: DID_W] & did_mask;
            if (wr_be[DRAIN_LANE]) begin
                drd_q <= wr_data[DRD_BIT] & cap_rd;
                dwr_q <= wr_data[DWR_BIT] & cap_wr;
            end
        end
    end

    logic unused_fields;
    assign unused_fields = ^{wr_be, wr_data};

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({did_q, drd_q, dwr_q}));

endmodule

// File: rtl/iotlb_inv_seq.sv
// Busy/request sequencer: starts a request on a software write, pulses the
// engine strobe, and records the performed granularity on completion.
// Assumes the engine raises done at most once per request, after eng_req.
module iotlb_inv_seq
    import iotlb_inv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_lane,
    input  logic       wr_busy_bit,
    input  logic [1:0] wr_gran,
    input  logic       eng_done,
    input  logic [1:0] eng_done_gran,
    input  logic       eng_done_err,
    output logic       busy_q,
    output gran_e      req_q,
    output gran_e      act_q,
    output logic       eng_req_q
);

    logic wr_ok, accept_done;
    assign wr_ok       = wr_en && wr_lane && !busy_q;
    assign accept_done = busy_q && !eng_req_q && eng_done;

    // Advance busy, requested and actual granularity, and the engine strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            req_q     <= GR_NONE;
            act_q     <= GR_GLOBAL;
            eng_req_q <= 1'b0;
        end else begin
            eng_req_q <= 1'b0;
            if (wr_ok) begin
                req_q <= gran_e'(wr_gran);
                if (wr_busy_bit) begin
                    if (wr_gran == GR_NONE) begin
                        act_q <= GR_NONE;
                    end else begin
                        busy_q    <= 1'b1;
                        eng_req_q <= 1'b1;
                    end
                end
            end else if (accept_done) begin
                busy_q <= 1'b0;
                act_q  <= coarsen(req_q, eng_done_gran, eng_done_err);
            end
        end
    end

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_q |=> !eng_req_q);

    // R7
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(eng_done));

    // R8
    not_finer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (act_q == GR_NONE || act_q <= req_q));

    // R11
    idle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !(wr_en && wr_lane)) |=> $stable(act_q));

endmodule

// File: rtl/iotlb_inv_cmd.sv
// Top of the invalidation command register: derives the domain mask from the
// capability width, assembles the read word, registers read data and drives
// the engine request bus. Assumes one register, no address decode.
module iotlb_inv_cmd
    import iotlb_inv_pkg::*;
#(
    parameter int DID_W = 8,
    localparam int CAPW = $clog2(DID_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAPW-1:0]   cap_did_width,
    input  logic              cap_drain_rd,
    input  logic              cap_drain_wr,
    input  logic              wr_en,
    input  logic [7:0]        wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              eng_req,
    output logic [1:0]        eng_gran,
    output logic [DID_W-1:0]  eng_did,
    output logic              eng_drain_rd,
    output logic              eng_drain_wr,
    input  logic              eng_done,
    input  logic [1:0]        eng_done_gran,
    input  logic              eng_done_err
);

    localparam int TOP_LANE = BUSY_BIT / 8;

    logic [DID_W-1:0] did_mask, did_q;
    logic             drd_q, dwr_q, busy_q, eng_req_q;
    gran_e            req_q, act_q;
    logic [WORD_W-1:0] word, rd_q;

    // One mask bit per implemented domain-id bit below the capability width.
    always_comb begin
        for (int i = 0; i < DID_W; i++)
            did_mask[i] = (32'(cap_did_width) > i);
    end

    iotlb_inv_fields #(.DID_W(DID_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .busy(busy_q),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .did_mask(did_mask), .cap_rd(cap_drain_rd), .cap_wr(cap_drain_wr),
        .did_q(did_q), .drd_q(drd_q), .dwr_q(dwr_q)
    );

    iotlb_inv_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_lane(wr_be[TOP_LANE]),
        .wr_busy_bit(wr_data[BUSY_BIT]), .wr_gran(wr_data[REQ_LO +: 2]),
        .eng_done(eng_done), .eng_done_gran(eng_done_gran),
        .eng_done_err(eng_done_err),
        .busy_q(busy_q), .req_q(req_q), .act_q(act_q), .eng_req_q(eng_req_q)
    );

    // Place each field at its position; everything else reads zero.
    always_comb begin
        word                  = '0;
        word[BUSY_BIT]        = busy_q;
        word[REQ_LO +: 2]     = req_q;
        word[ACT_LO +: 2]     = act_q;
        word[DRD_BIT]         = drd_q;
        word[DWR_BIT]         = dwr_q;
        word[DID_LO +: DID_W] = did_q & did_mask;
    end

    // Capture the word on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= word;
    end

    assign rd_data      = rd_q;
    assign eng_req      = eng_req_q;
    assign eng_gran     = req_q;
    assign eng_did      = did_q & did_mask;
    assign eng_drain_rd = drd_q;
    assign eng_drain_wr = dwr_q;

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/iotlb_inv_cmd_bench.sv
module iotlb_inv_cmd_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cap_n = 4'd8;
    logic        cap_rd = 1'b1, cap_wr = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        eng_req, eng_drain_rd, eng_drain_wr;
    logic [1:0]  eng_gran;
    logic [7:0]  eng_did;
    logic        done = 1'b0, derr = 1'b0;
    logic [1:0]  dgran = '0;

    int vectors = 0, fails = 0;

    iotlb_inv_cmd u_iotlb_inv_cmd (
        .clk(clk), .rst_n(rst_n), .cap_did_width(cap_n),
        .cap_drain_rd(cap_rd), .cap_drain_wr(cap_wr),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .eng_req(eng_req), .eng_gran(eng_gran), .eng_did(eng_did),
        .eng_drain_rd(eng_drain_rd), .eng_drain_wr(eng_drain_wr),
        .eng_done(done), .eng_done_gran(dgran), .eng_done_err(derr)
    );

    always #10 clk = ~clk;

    // Behavioural reference state
    bit        m_busy, m_dr, m_dw, m_ereq;
    bit [1:0]  m_rq, m_act;
    bit [7:0]  m_did;
    bit [63:0] m_rd;

    function automatic bit [7:0] msk(input bit [3:0] n);
        return (n >= 8) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
    endfunction

    function automatic bit [63:0] mword();
        bit [63:0] w = '0;
        w[63] = m_busy; w[61:60] = m_rq; w[58:57] = m_act;
        w[49] = m_dr; w[48] = m_dw; w[39:32] = m_did & msk(cap_n);
        return w;
    endfunction

    always @(posedge clk) begin
        bit nreq;
        if (!rst_n) begin
            m_busy = 0; m_rq = 0; m_act = 2'b01; m_dr = 0; m_dw = 0;
            m_did = 0; m_ereq = 0; m_rd = '0;
        end else begin
            if (rd_en) m_rd = mword();
            nreq = 0;
            if (wr_en && !m_busy) begin
                if (wr_be[7]) begin
                    m_rq = wr_data[61:60];
                    if (wr_data[63]) begin
                        if (m_rq == 0) m_act = 0;
                        else begin m_busy = 1; nreq = 1; end
                    end
                end
                if (wr_be[6]) begin
                    m_dr = wr_data[49] & cap_rd;
                    m_dw = wr_data[48] & cap_wr;
                end
                if (wr_be[4]) m_did = wr_data[39:32] & msk(cap_n);
            end else if (m_busy && !m_ereq && done) begin
                m_busy = 0;
                if (derr) m_act = 0;
                else if (dgran == 0 || dgran > m_rq) m_act = m_rq;
                else m_act = dgran;
            end
            m_ereq = nreq;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R12", "rd_data vs model", rd_data, m_rd);
        check("R5", "eng_req vs model", 64'(eng_req), 64'(m_ereq));
        if (m_ereq) begin
            check("R5", "eng_gran vs model", 64'(eng_gran), 64'(m_rq));
            check("R3", "eng_did vs model", 64'(eng_did), 64'(m_did & msk(cap_n)));
            check("R4", "eng drains vs model", 64'({eng_drain_rd, eng_drain_wr}),
                  64'({m_dr, m_dw}));
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [7:0] be, input logic [63:0] d);
        wr_en = 1; wr_be = be; wr_data = d;
        step();
        wr_en = 0; wr_be = '0; wr_data = '0;
    endtask

    task automatic rdchk(input string tag, input logic [63:0] exp);
        rd_en = 1;
        step();
        rd_en = 0;
        check(tag, "read word", rd_data, exp);
    endtask

    task automatic fin(input logic [1:0] g, input logic e);
        done = 1; dgran = g; derr = e;
        step();
        done = 0; dgran = 0; derr = 0;
    endtask

    // Start a request of code g and check the strobe cycle.
    task automatic start(input logic [1:0] g, input string tag);
        wr(8'h80, {1'b1, 1'b0, g, 60'h0});
        check(tag, "eng_req after start", 64'(eng_req), 64'd1);
        check(tag, "eng_gran after start", 64'(eng_gran), 64'(g));
        step();
        check(tag, "eng_req single cycle", 64'(eng_req), 64'd0);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset value
        rdchk("R1", 64'h0200_0000_0000_0000);
        check("R1", "eng_req idle", 64'(eng_req), 64'd0);

        // R2 reserved bits read zero after writing all ones (busy kept 0)
        wr(8'hFF, 64'h7FFF_FFFF_FFFF_FFFF);
        rdchk("R2", 64'h3203_00FF_0000_0000);

        // R13 lane 4 alone, then only unwritable lanes
        wr(8'h10, 64'h0);
        rdchk("R13", 64'h3203_0000_0000_0000);
        wr(8'h2F, 64'hFFFF_FFFF_FFFF_FFFF);
        rdchk("R13", 64'h3203_0000_0000_0000);

        // R3 domain width limits
        cap_n = 4'd4;
        wr(8'h10, 64'h0000_00FF_0000_0000);
        rdchk("R3", 64'h3203_000F_0000_0000);
        cap_n = 4'd0;
        wr(8'h10, 64'h0000_00FF_0000_0000);
        rdchk("R3", 64'h3203_0000_0000_0000);
        cap_n = 4'd8;

        // R4 drain capability gating
        cap_rd = 0;
        wr(8'h40, 64'h0003_0000_0000_0000);
        rdchk("R4", 64'h3201_0000_0000_0000);
        cap_wr = 0; cap_rd = 1; cap_wr = 0;
        wr(8'h40, 64'h0003_0000_0000_0000);
        rdchk("R4", 64'h3202_0000_0000_0000);
        cap_rd = 1; cap_wr = 1;

        // R5 start a domain request with fields in the same write
        wr(8'hD0, 64'hA003_005A_0000_0000);
        check("R5", "eng_req", 64'(eng_req), 64'd1);
        check("R5", "eng_did", 64'(eng_did), 64'h5A);
        check("R5", "eng drains", 64'({eng_drain_rd, eng_drain_wr}), 64'd3);
        step();
        check("R5", "eng_req one cycle", 64'(eng_req), 64'd0);
        rdchk("R5", 64'hA203_005A_0000_0000);

        // R6 write while busy ignored
        wr(8'hFF, 64'h0);
        rdchk("R6", 64'hA203_005A_0000_0000);

        // R7 coarser result recorded
        fin(2'b01, 0);
        rdchk("R7", 64'h2203_005A_0000_0000);

        // R7 page request done as domain
        start(2'b11, "R7");
        fin(2'b10, 0);
        rdchk("R7", 64'h3403_005A_0000_0000);

        // R8 finer result clamped to request
        start(2'b10, "R8");
        fin(2'b11, 0);
        rdchk("R8", 64'h2403_005A_0000_0000);
        start(2'b11, "R8");
        fin(2'b00, 0);
        rdchk("R8", 64'h3603_005A_0000_0000);

        // R9 error result
        start(2'b01, "R9");
        fin(2'b01, 1);
        rdchk("R9", 64'h1003_005A_0000_0000);

        // R10 start with code 00
        wr(8'h80, 64'h8000_0000_0000_0000);
        check("R10", "no eng_req", 64'(eng_req), 64'd0);
        rdchk("R10", 64'h0003_005A_0000_0000);

        // R11 done while idle
        start(2'b01, "R11");
        fin(2'b01, 0);
        fin(2'b11, 1);
        rdchk("R11", 64'h1203_005A_0000_0000);

        // R12 read data holds without rd_en
        wr(8'h10, 64'h0000_0011_0000_0000);
        step();
        check("R12", "hold", rd_data, 64'h1203_005A_0000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule